// File: doc/BRIEF.md
# Egress Queue Strict-Priority Scheduler

The block decides which of several transmit queues may send onto a single egress port. Each queue presents two flags: one says a packet waits at its head, the other comes from that queue's own rate shaper and says the queue is allowed to send now. A queue competes only when both flags are set. In strict mode the queue with the highest index wins. A queue that keeps both flags set therefore keeps the port. In fallback mode the competing queues are served in round-robin order.

A grant lasts for a whole packet. Once a queue is granted, the grant stays with it until a beat marked end-of-packet has actually moved. A port-wide eligibility input, driven by a limiter after arbitration, freezes the transfer of beats and also keeps a new grant from starting while it is low. Beat movement is reported through a take strobe that the queue storage uses to pop its head.

Top module: `txq_egress_sched`

## Requirements
- R1: While and right after reset, no queue is granted (`gnt` all zero, `gnt_vld` low, `beat_take` low), and the round-robin pointer points at the last queue, so the first round-robin search starts at queue 0.
- R2: A queue competes only when its bits in both `q_req` and `q_elig` are 1. A requesting queue whose eligibility bit is 0 is never granted.
- R3: With `strict_en` = 1, the competing queue with the highest index is granted. Queue NUM_Q-1 has the highest priority and queue 0 the lowest.
- R4: Arbitration happens in a cycle where there is no grant, `port_elig` = 1 and at least one queue competes. The grant appears on the outputs in the following cycle, not in the arbitration cycle.
- R5: A grant stays on the same queue until a beat with `pkt_eop` = 1 is taken. Other queues, including higher-priority ones, do not preempt it. `pkt_eop` has no effect in a cycle where no beat is taken.
- R6: After the end-of-packet beat is taken, the next cycle has no grant and arbitration runs again in that cycle. In strict mode, a top queue that still competes is granted again.
- R7: While `port_elig` = 0, `beat_take` is 0, a held grant stays on its queue, and no new grant starts.
- R8: When no queue competes, no grant is given and the port stays idle.
- R9: With `strict_en` = 0, the grant goes to the first competing queue found searching upward from the last granted queue plus one, wrapping from NUM_Q-1 to 0. Each new grant, in either mode, moves the pointer to the granted queue.
- R10: `gnt` is one-hot or zero, equals 1 shifted left by `gnt_qid` whenever `gnt_vld` = 1, and `beat_take` = `gnt_vld` AND `port_elig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_en | input | 1 | 1 selects strict priority, 0 selects round-robin |
| q_req | input | NUM_Q | Per-queue head-of-line packet present |
| q_elig | input | NUM_Q | Per-queue shaper eligibility |
| port_elig | input | 1 | Port-wide limiter permission |
| pkt_eop | input | 1 | Current beat of the granted queue ends its packet |
| gnt | output | NUM_Q | One-hot grant |
| gnt_vld | output | 1 | A queue holds the grant |
| gnt_qid | output | log2(NUM_Q) | Index of the granted queue |
| beat_take | output | 1 | A beat of the granted queue moves this cycle |

## Verification
The assertions assume that `pkt_eop` describes the granted queue's current head beat and that a granted queue keeps requesting until its packet ends. They also assume that `q_req`, `q_elig` and `port_elig` are driven to known values from time zero and sampled at the clock edge. The bench drives every input shortly after the falling edge, holds the inputs steady across the rising edge, and raises `pkt_eop` only while a grant is held. This keeps the end-of-packet handshake consistent with a real queue.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

   typedef enum logic {
      ARB_ROUND_ROBIN = 1'b0,
      ARB_STRICT      = 1'b1
   } arb_mode_e;

   function automatic arb_mode_e mode_of(input logic strict_bit, input bit rr_built);
      if (!rr_built || strict_bit) return ARB_STRICT;
      return ARB_ROUND_ROBIN;
   endfunction

endpackage

// File: rtl/txq_prio_find.sv
module txq_prio_find #(
   parameter int NUM_Q = 8,
   localparam int QW = $clog2(NUM_Q)
) (
   input  logic [NUM_Q-1:0] cand,
   output logic             any,
   output logic [QW-1:0]    idx
);

   generate
      if (NUM_Q < 2) begin : g_bad_cfg
         $error("txq_prio_find needs at least two queues");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_Q; i++) begin
         if (cand[i]) idx = QW'(i);
      end
   end

   assign any = |cand;

endmodule

// File: rtl/txq_rr_find.sv
module txq_rr_find #(
   parameter int NUM_Q = 8,
   localparam int QW = $clog2(NUM_Q)
) (
   input  logic [NUM_Q-1:0] cand,
   input  logic [QW-1:0]    last,
   output logic [QW-1:0]    idx
);

   always_comb begin
      idx = last;
      for (int k = NUM_Q; k >= 1; k--) begin
         int pos;
         pos = int'(last) + k;
         if (pos >= NUM_Q) pos = pos - NUM_Q;
         if (cand[pos]) idx = QW'(pos);
      end
   end

endmodule

// File: rtl/txq_lock_ctrl.sv
module txq_lock_ctrl #(
   parameter int NUM_Q = 8,
   localparam int QW = $clog2(NUM_Q)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_Q-1:0] cand,
   input  logic             cand_any,
   input  logic [QW-1:0]    pick,
   input  txq_sched_pkg::arb_mode_e mode,
   input  logic             port_elig,
   input  logic             pkt_eop,
   output logic             locked,
   output logic [QW-1:0]    qid,
   output logic [QW-1:0]    rr_last
);
   import txq_sched_pkg::*;

   logic start, finish;

   assign start  = !locked && port_elig && cand_any;
   assign finish = locked && port_elig && pkt_eop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked  <= 1'b0;
         qid     <= '0;
         rr_last <= QW'(NUM_Q - 1);
      end else if (start) begin
         locked  <= 1'b1;
         qid     <= pick;
         rr_last <= pick;
      end else if (finish) begin
         locked  <= 1'b0;
      end
   end

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(port_elig && pkt_eop)) |=> (locked && $stable(qid))); // R5

   AST_LOCK_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ((($past(cand) >> qid) & NUM_Q'(1)) != '0)); // R2

   AST_STRICT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(locked) && $past(mode) == ARB_STRICT) |-> ((($past(cand) >> qid) >> 1) == '0)); // R3

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !port_elig) |=> (locked && $stable(qid))); // R7

   AST_STALL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !port_elig) |=> !locked); // R7

   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && cand == '0) |=> !locked); // R8

   AST_NEXT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && port_elig && cand != '0) |=> locked); // R4

endmodule

// File: rtl/txq_egress_sched.sv
module txq_egress_sched #(
   parameter int NUM_Q = 8,
   parameter bit HAS_RR = 1'b1,
   localparam int QW = $clog2(NUM_Q)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strict_en,
   input  logic [NUM_Q-1:0] q_req,
   input  logic [NUM_Q-1:0] q_elig,
   input  logic             port_elig,
   input  logic             pkt_eop,
   output logic [NUM_Q-1:0] gnt,
   output logic             gnt_vld,
   output logic [QW-1:0]    gnt_qid,
   output logic             beat_take
);
   import txq_sched_pkg::*;

   generate
      if (NUM_Q < 2 || NUM_Q > 256) begin : g_bad_cfg
         $error("txq_egress_sched: NUM_Q must lie in 2..256");
      end
   endgenerate

   logic [NUM_Q-1:0] cand;
   logic             cand_any;
   logic [QW-1:0]    prio_idx, pick, rr_last;
   logic             locked;
   logic [QW-1:0]    qid;
   arb_mode_e        mode;

   assign cand = q_req & q_elig;
   assign mode = mode_of(strict_en, HAS_RR);

   txq_prio_find #(.NUM_Q(NUM_Q)) u_prio (
      .cand (cand),
      .any  (cand_any),
      .idx  (prio_idx)
   );

   generate
      if (HAS_RR) begin : g_rr
         logic [QW-1:0] rr_idx;
         txq_rr_find #(.NUM_Q(NUM_Q)) u_rr (
            .cand (cand),
            .last (rr_last),
            .idx  (rr_idx)
         );
         assign pick = (mode == ARB_STRICT) ? prio_idx : rr_idx;
      end else begin : g_strict_only
         assign pick = prio_idx;
      end
   endgenerate

   txq_lock_ctrl #(.NUM_Q(NUM_Q)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand      (cand),
      .cand_any  (cand_any),
      .pick      (pick),
      .mode      (mode),
      .port_elig (port_elig),
      .pkt_eop   (pkt_eop),
      .locked    (locked),
      .qid       (qid),
      .rr_last   (rr_last)
   );

   generate
      for (genvar g = 0; g < NUM_Q; g++) begin : g_gnt
         assign gnt[g] = locked && (qid == QW'(g));
      end
   endgenerate

   assign gnt_vld   = locked;
   assign gnt_qid   = qid;
   assign beat_take = locked && port_elig;

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && (gnt_vld == (gnt != '0))); // R10

   AST_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !port_elig |-> !beat_take); // R7

endmodule

// File: tb/txq_egress_sched_tb.sv
`timescale 1ns/100ps
module txq_egress_sched_tb;
   localparam int NQ = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strict_en = 1'b1;
   logic [NQ-1:0] q_req = '0;
   logic [NQ-1:0] q_elig = '0;
   logic          port_elig = 1'b0;
   logic          pkt_eop = 1'b0;
   logic [NQ-1:0] gnt;
   logic          gnt_vld;
   logic [2:0]    gnt_qid;
   logic          beat_take;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   txq_egress_sched #(.NUM_Q(NQ)) u_dut (
      .clk(clk), .rst_n(rst_n), .strict_en(strict_en), .q_req(q_req),
      .q_elig(q_elig), .port_elig(port_elig), .pkt_eop(pkt_eop),
      .gnt(gnt), .gnt_vld(gnt_vld), .gnt_qid(gnt_qid), .beat_take(beat_take)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic expect_grant(input int q, input string req);
      #1;
      chk(gnt_vld === 1'b1, req, int'(gnt_vld), 1);
      chk(gnt_qid === 3'(q), req, int'(gnt_qid), q);
      chk(gnt === NQ'(1) << q, "R10", int'(gnt), 1 << q);
   endtask

   task automatic expect_idle(input string req);
      #1;
      chk(gnt_vld === 1'b0 && gnt === '0, req, int'(gnt), 0);
   endtask

   task automatic end_packet();
      port_elig = 1'b1;
      pkt_eop = 1'b1;
      cyc();
      pkt_eop = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc();
      cyc();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      q_req = 8'hFF; q_elig = 8'hFF; port_elig = 1'b1;
      #1;
      chk(gnt_vld === 1'b0 && gnt === '0, "R1", int'(gnt), 0);
      chk(beat_take === 1'b0, "R1", int'(beat_take), 0);
      q_req = '0;
      cyc();
   endtask

   task automatic t_strict_pick();
      strict_en = 1'b1; q_req = 8'hA6; q_elig = 8'hFF; port_elig = 1'b1; pkt_eop = 1'b0;
      expect_idle("R4");
      cyc();
      expect_grant(7, "R3");
      chk(beat_take === 1'b1, "R10", int'(beat_take), 1);
      end_packet();
      expect_idle("R6");
   endtask

   task automatic t_ineligible();
      q_req = 8'hFF; q_elig = 8'h7F;
      cyc();
      expect_grant(6, "R2");
   endtask

   task automatic t_lock_and_stall();
      q_elig = 8'hFF;
      repeat (3) cyc();
      expect_grant(6, "R5");
      port_elig = 1'b0; pkt_eop = 1'b1;
      #1;
      chk(beat_take === 1'b0, "R7", int'(beat_take), 0);
      cyc();
      expect_grant(6, "R5");
      end_packet();
      port_elig = 1'b0;
      cyc();
      cyc();
      expect_idle("R7");
      port_elig = 1'b1;
      cyc();
      expect_grant(7, "R7");
      end_packet();
   endtask

   task automatic t_empty();
      q_req = '0; q_elig = 8'hFF;
      cyc();
      expect_idle("R8");
      q_req = 8'hF0; q_elig = 8'h0F;
      cyc();
      expect_idle("R8");
   endtask

   task automatic t_repeat_top();
      q_req = 8'h20; q_elig = 8'hFF;
      cyc();
      expect_grant(5, "R3");
      end_packet();
      expect_idle("R6");
      cyc();
      expect_grant(5, "R6");
      end_packet();
      q_req = '0;
      cyc();
   endtask

   task automatic rr_one(input int q);
      pkt_eop = 1'b0;
      cyc();
      expect_grant(q, "R9");
      end_packet();
      expect_idle("R6");
   endtask

   task automatic t_round_robin();
      q_req = '0;
      do_reset();
      strict_en = 1'b0; q_req = 8'h85; q_elig = 8'hFF; port_elig = 1'b1;
      rr_one(0);
      rr_one(2);
      rr_one(7);
      rr_one(0);
      q_req = 8'hFF; q_elig = 8'h11;
      rr_one(4);
      rr_one(0);
      rr_one(4);
      q_req = '0;
      cyc();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
   endtask

   initial begin : watchdog
      #800000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      t_reset();
      t_strict_pick();
      t_ineligible();
      t_lock_and_stall();
      t_empty();
      t_repeat_top();
      t_round_robin();
      done = 1;
      summary();
      $finish;
   end

endmodule